// File: doc/BRIEF.md
# NAND Flash Bus Strobe Timer

This block runs single transfers on an asynchronous NAND flash bus. Each request is one command, address or data transfer. The block asserts chip enable and drives the active-low write or read strobe. It drives or samples the data lines and raises the command or address latch line that matches the transfer kind. It then answers with a one-clock acknowledge. Higher-level sequencing of pages, error correction and DMA sit outside it.

All timing comes from a packed 32-bit timing word and is counted in system clocks. Low and high phases are given as edge positions within one strobe period. Two extras apply only to reads: a chip-enable-to-read-strobe lead time and a bus turnaround after the read. Writes flagged as starting a busy operation wait a programmable settling delay. After that delay the ready input is polled. The timing word is sampled once, when a request is accepted, so software may rewrite it while a transfer is in flight.

Top module: `nst_strobe_timer`

## Requirements
- R1: The timing word is decoded as follows:
  - bits 3:0 write low edge (WL)
  - bits 7:4 write high edge (WH)
  - bits 11:8 read low edge (RL)
  - bits 15:12 read high edge (RH)
  - bits 18:16 turnaround (TA)
  - bits 23:19 busy delay (BD)
  - bits 25:24 chip-enable lead (CE)

  The word is sampled only on the clock that accepts a request, and later changes do not affect that transfer.
- R2: On a write, `nand_we_n` is low for exactly WL+1 clocks, starting in the first clock after acceptance.
- R3: The write high phase lasts WH−WL clocks, or 1 clock when WH ≤ WL. A write without busy wait is acknowledged after WL+1 plus the high phase, counted in clocks with `nand_ce_n` low.
- R4: On a read, `nand_ce_n` is low for CE clocks before `nand_re_n` falls. `nand_re_n` then stays low for exactly RL+1 clocks.
- R5: The read high phase lasts RH−RL clocks, or 1 clock when RH ≤ RL.
- R6: Read data is captured in the last clock of the read low phase. `rd_data` keeps that value through later writes until the next read captures new data.
- R7: A read keeps `nand_ce_n` low for CE + (RL+1) + high phase + TA clocks before acknowledging. `nand_oe` stays low throughout a read.
- R8: On a write with `req_wait_busy`=1, `nand_ready` is ignored for BD clocks after the high phase. It is then tested once per clock, and the transfer completes in the clock where it is seen high.
- R9: `req_ack` is a single-clock pulse in the first clock after the transfer, with `nand_ce_n` already high. A request still held during that clock is ignored.
- R10: `nand_we_n` and `nand_re_n` are never low together, and neither is low while `nand_ce_n` is high. `nand_oe` is high during the write low and high phases, with `nand_dout` equal to the accepted write data.
- R11: During and after reset:
  - `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1
  - `req_ack`, `nand_oe`, `nand_cle` and `nand_ale` are 0
  - `rd_data` is 0
- R12: `req_kind` encodes 0 data, 1 command, 2 address and 3 data. `nand_cle` is high through a command transfer and `nand_ale` through an address transfer. Both are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| timing_cfg | input | 32 | Packed timing word |
| req_valid | input | 1 | Transfer request, held until acknowledge |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 2 | Transfer kind: data, command or address |
| req_wait_busy | input | 1 | Write starts a busy operation |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | Transfer complete pulse |
| rd_data | output | DW | Last read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_oe | output | 1 | Data output enable |
| nand_dout | output | DW | Data to flash |
| nand_din | input | DW | Data from flash |
| nand_ready | input | 1 | Flash ready (1) or busy (0) |

## Verification
The bound checker watches every cycle for the following:
- strobe exclusivity and strobes held inactive without chip enable
- the bus left undriven while the read strobe is low
- the acknowledge being a single pulse with chip enable already released
- `rd_data` changing only right after a read strobe clock
- the two latch lines never being high together

Phase lengths, chip-enable lead, turnaround, busy delay, sampling of the timing word at acceptance and the captured data value can only be shown by the bench's transfers. The bench counts strobe and chip-enable clocks per transfer against values computed from the timing word.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int CFG_W   = 32;
  localparam int POS_W   = 4;
  localparam int TA_W    = 3;
  localparam int BSY_W   = 5;
  localparam int CEL_W   = 2;
  localparam int TA_OFS  = 16;
  localparam int BSY_OFS = TA_OFS + TA_W;
  localparam int CEL_OFS = BSY_OFS + BSY_W;
  localparam int USED_W  = CEL_OFS + CEL_W;
  localparam int CNT_W   = (POS_W + 1 > BSY_W) ? POS_W + 1 : BSY_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CEW, S_LOW, S_HIGH, S_TURN, S_BUSY, S_RB
  } st_e;

  typedef enum logic [1:0] {
    K_DATA = 2'd0, K_CMD = 2'd1, K_ADDR = 2'd2, K_DATA2 = 2'd3
  } kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] wr_lo;
    logic [CNT_W-1:0] wr_hi;
    logic [CNT_W-1:0] rd_lo;
    logic [CNT_W-1:0] rd_hi;
    logic [TA_W-1:0]  ta;
    logic [BSY_W-1:0] bsy;
    logic [CEL_W-1:0] cel;
  } tim_t;
endpackage

// File: rtl/nst_down_counter.sv
module nst_down_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nst_cfg_decode.sv
module nst_cfg_decode
  import nst_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output tim_t             tim_o
);
  logic [1:0][CNT_W-1:0] lo_len, hi_len;

  // index 0 = write edges, index 1 = read edges
  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic [POS_W-1:0] lo_pos, hi_pos;
    assign lo_pos    = cfg_i[g*2*POS_W +: POS_W];
    assign hi_pos    = cfg_i[g*2*POS_W + POS_W +: POS_W];
    assign lo_len[g] = CNT_W'(lo_pos) + CNT_W'(1);
    assign hi_len[g] = (hi_pos > lo_pos) ? CNT_W'(hi_pos - lo_pos) : CNT_W'(1);
  end

  assign tim_o.wr_lo = lo_len[0];
  assign tim_o.wr_hi = hi_len[0];
  assign tim_o.rd_lo = lo_len[1];
  assign tim_o.rd_hi = hi_len[1];
  assign tim_o.ta    = cfg_i[TA_OFS  +: TA_W];
  assign tim_o.bsy   = cfg_i[BSY_OFS +: BSY_W];
  assign tim_o.cel   = cfg_i[CEL_OFS +: CEL_W];

  logic unused_cfg_hi;
  assign unused_cfg_hi = ^cfg_i[CFG_W-1:USED_W];
endmodule

// File: rtl/nst_strobe_timer.sv
module nst_strobe_timer
  import nst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] timing_cfg,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_kind,
  input  logic             req_wait_busy,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack,
  output logic [DW-1:0]    rd_data,
  output logic             nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_oe,
  output logic [DW-1:0]    nand_dout,
  input  logic [DW-1:0]    nand_din,
  input  logic             nand_ready
);
  tim_t             live;
  st_e              st_q, st_d;
  logic             accept, finish, ld, zero, cap;
  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] lo_q, hi_q;
  logic [TA_W-1:0]  ta_q;
  logic [BSY_W-1:0] bsy_q;
  logic             wr_q, wb_q, wr_n;
  kind_e            kind_q, kind_n;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             ce_n_q, we_n_q, re_n_q, cle_q, ale_q, oe_q, ack_q;

  nst_cfg_decode u_dec (.cfg_i(timing_cfg), .tim_o(live));

  nst_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .zero_o(zero)
  );

  assign accept = (st_q == S_IDLE) && !ack_q && req_valid;
  assign cap    = (st_q == S_LOW) && zero && !wr_q;
  assign wr_n   = accept ? req_write : wr_q;
  assign kind_n = accept ? kind_e'(req_kind) : kind_q;

  // next state and counter loads
  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    finish = 1'b0;
    unique case (st_q)
      S_IDLE: if (accept) begin
        ld = 1'b1;
        if (!req_write && live.cel != '0) begin
          st_d   = S_CEW;
          ld_val = CNT_W'(live.cel) - CNT_W'(1);
        end else begin
          st_d   = S_LOW;
          ld_val = (req_write ? live.wr_lo : live.rd_lo) - CNT_W'(1);
        end
      end
      S_CEW: if (zero) begin
        st_d = S_LOW; ld = 1'b1; ld_val = lo_q - CNT_W'(1);
      end
      S_LOW: if (zero) begin
        st_d = S_HIGH; ld = 1'b1; ld_val = hi_q - CNT_W'(1);
      end
      S_HIGH: if (zero) begin
        if (!wr_q) begin
          if (ta_q != '0) begin
            st_d = S_TURN; ld = 1'b1; ld_val = CNT_W'(ta_q) - CNT_W'(1);
          end else finish = 1'b1;
        end else if (wb_q) begin
          if (bsy_q != '0) begin
            st_d = S_BUSY; ld = 1'b1; ld_val = CNT_W'(bsy_q) - CNT_W'(1);
          end else st_d = S_RB;
        end else finish = 1'b1;
      end
      S_TURN: if (zero) finish = 1'b1;
      S_BUSY: if (zero) st_d = S_RB;
      S_RB:   if (nand_ready) finish = 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (finish) st_d = S_IDLE;
  end

  // state and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      re_n_q <= 1'b1;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      oe_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ce_n_q <= (st_d == S_IDLE);
      we_n_q <= !((st_d == S_LOW) && wr_n);
      re_n_q <= !((st_d == S_LOW) && !wr_n);
      cle_q  <= (st_d != S_IDLE) && (kind_n == K_CMD);
      ale_q  <= (st_d != S_IDLE) && (kind_n == K_ADDR);
      oe_q   <= wr_n && ((st_d == S_LOW) || (st_d == S_HIGH));
      ack_q  <= finish;
    end
  end

  // request fields, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      ta_q    <= '0;
      bsy_q   <= '0;
      wr_q    <= 1'b0;
      wb_q    <= 1'b0;
      kind_q  <= K_DATA;
      wdata_q <= '0;
    end else if (accept) begin
      lo_q    <= req_write ? live.wr_lo : live.rd_lo;
      hi_q    <= req_write ? live.wr_hi : live.rd_hi;
      ta_q    <= live.ta;
      bsy_q   <= live.bsy;
      wr_q    <= req_write;
      wb_q    <= req_wait_busy;
      kind_q  <= kind_e'(req_kind);
      wdata_q <= req_wdata;
    end
  end

  // read capture, enabled in last low clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= nand_din;
  end

  assign req_ack   = ack_q;
  assign rd_data   = rdata_q;
  assign nand_ce_n = ce_n_q;
  assign nand_we_n = we_n_q;
  assign nand_re_n = re_n_q;
  assign nand_cle  = cle_q;
  assign nand_ale  = ale_q;
  assign nand_oe   = oe_q;
  assign nand_dout = wdata_q;
endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ack,
  input logic [DW-1:0] rd_data,
  input logic          nand_ce_n,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_oe
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R10
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ce_n |-> (nand_we_n && nand_re_n));

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_oe);

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R9
  ack_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> nand_ce_n);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(!nand_re_n));

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
endmodule

bind nst_strobe_timer nst_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .rd_data(rd_data),
  .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_oe(nand_oe)
);

// File: tb/nst_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module nst_strobe_timer_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   timing_cfg;
  logic          req_valid, req_write, req_wait_busy;
  logic [1:0]    req_kind;
  logic [DW-1:0] req_wdata, din_drv, last_rd;
  logic          req_ack, nand_ce_n, nand_we_n, nand_re_n;
  logic          nand_cle, nand_ale, nand_oe, nand_ready;
  logic [DW-1:0] rd_data, nand_dout, nand_din;
  int            checks = 0;
  int            fails  = 0;
  bit            done_flag = 0;

  always #2.5 clk = ~clk;

  assign nand_din = nand_re_n ? '0 : din_drv;

  nst_strobe_timer #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .req_valid(req_valid),
    .req_write(req_write), .req_kind(req_kind), .req_wait_busy(req_wait_busy),
    .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_oe(nand_oe),
    .nand_dout(nand_dout), .nand_din(nand_din), .nand_ready(nand_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int wl, int wh, int rl, int rh, int ta, int bd, int ce);
    return {6'd0, 2'(ce), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endfunction

  function automatic int lo_len(logic [31:0] c, bit wr);
    return wr ? int'(c[3:0]) + 1 : int'(c[11:8]) + 1;
  endfunction

  function automatic int hi_len(logic [31:0] c, bit wr);
    int lo = wr ? int'(c[3:0])  : int'(c[11:8]);
    int hi = wr ? int'(c[7:4])  : int'(c[15:12]);
    return (hi > lo) ? hi - lo : 1;
  endfunction

  function automatic int total_len(logic [31:0] c, bit wr, bit wb, int lag);
    int t0;
    if (!wr) return int'(c[25:24]) + lo_len(c, 0) + hi_len(c, 0) + int'(c[18:16]);
    if (!wb) return lo_len(c, 1) + hi_len(c, 1);
    t0 = lo_len(c, 1) + hi_len(c, 1) + int'(c[23:19]);
    return ((lag > t0) ? lag : t0) + 1;
  endfunction

  task automatic run_txn(input logic [31:0] c, input logic [31:0] c_mid, input bit wr,
                         input logic [1:0] k, input bit wb, input int lag,
                         input logic [DW-1:0] wd, input logic [DW-1:0] rdv, input bit hold);
    int n = 0, lo_cnt = 0, pre_cnt = 0, n_exp;
    bit seen = 0, got = 0, ctl_bad = 0, oe_bad = 0;
    string tag;
    @(negedge clk);
    timing_cfg = c; req_write = wr; req_kind = k; req_wait_busy = wb;
    req_wdata = wd; din_drv = rdv; nand_ready = (lag <= 0); req_valid = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (req_ack) begin got = 1; break; end
      if (i == 1) timing_cfg = c_mid;
      nand_ready = (i >= lag);
      if (!nand_ce_n) n++;
      if (!(wr ? nand_we_n : nand_re_n)) begin lo_cnt++; seen = 1; end
      else if (!seen && !nand_ce_n) pre_cnt++;
      if (!nand_ce_n && (nand_cle != (k == 2'd1) || nand_ale != (k == 2'd2))) ctl_bad = 1;
      if (!wr && nand_oe) oe_bad = 1;
      if (wr && !nand_we_n && (!nand_oe || nand_dout != wd)) oe_bad = 1;
    end
    chk(got, "R9 ack seen", int'(got), 1);
    if (!hold) req_valid = 1'b0;
    n_exp = total_len(c, wr, wb, lag);
    if (c_mid != c)                      tag = "R1 total";
    else if (!wr && c[15:12] <= c[11:8]) tag = "R5 total";
    else if (!wr)                        tag = "R7 total";
    else if (wb)                         tag = "R8 total";
    else                                 tag = "R3 total";
    chk(n == n_exp, tag, n, n_exp);
    chk(lo_cnt == lo_len(c, wr), wr ? "R2 we low" : "R4 re low", lo_cnt, lo_len(c, wr));
    chk(pre_cnt == (wr ? 0 : int'(c[25:24])), "R4 ce lead", pre_cnt, wr ? 0 : int'(c[25:24]));
    chk(!ctl_bad, "R12 latch lines", int'(ctl_bad), 0);
    chk(!oe_bad, "R10 data drive", int'(oe_bad), 0);
    if (!wr) last_rd = rdv;
    chk(rd_data == last_rd, "R6 rd_data", int'(rd_data), int'(last_rd));
    @(negedge clk);
    chk(!req_ack, "R9 single pulse", int'(req_ack), 0);
    if (hold) begin
      req_valid = 1'b0;
      chk(nand_ce_n, "R9 held req ignored", int'(nand_ce_n), 1);
      @(negedge clk);
      chk(nand_ce_n && !req_ack, "R9 no restart", int'(nand_ce_n), 1);
    end
    nand_ready = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rc;
    void'($urandom(32'd7127));
    rst_n = 1'b0; timing_cfg = '0; req_valid = 1'b0; req_write = 1'b0;
    req_kind = '0; req_wait_busy = 1'b0; req_wdata = '0; din_drv = '0;
    nand_ready = 1'b1; last_rd = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes idle", int'(nand_ce_n), 1);
    chk(!req_ack && !nand_oe && !nand_cle && !nand_ale, "R11 controls low", int'(req_ack), 0);
    chk(rd_data == '0, "R11 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;

    run_txn(mk(0,0,0,0,0,0,0), mk(0,0,0,0,0,0,0), 0, 2'd0, 0, 0, 8'h00, 8'hA5, 0);
    run_txn(mk(0,0,0,0,0,0,0), mk(0,0,0,0,0,0,0), 1, 2'd1, 0, 0, 8'h3C, 8'h00, 0);
    run_txn(mk(5,3,0,0,0,0,0), mk(5,3,0,0,0,0,0), 1, 2'd2, 0, 0, 8'h81, 8'h00, 0);
    run_txn(mk(0,0,2,9,4,0,3), mk(0,0,2,9,4,0,3), 0, 2'd0, 0, 0, 8'h00, 8'h5A, 0);
    run_txn(mk(0,0,7,7,2,0,1), mk(0,0,7,7,2,0,1), 0, 2'd3, 0, 0, 8'h00, 8'hC3, 0);
    run_txn(mk(1,4,0,0,0,10,0), mk(1,4,0,0,0,10,0), 1, 2'd1, 1, 3, 8'h70, 8'h00, 0);
    run_txn(mk(2,2,0,0,0,0,0), mk(2,2,0,0,0,0,0), 1, 2'd1, 1, 20, 8'h60, 8'h00, 0);
    run_txn(mk(15,15,15,15,7,31,3), mk(15,15,15,15,7,31,3), 0, 2'd0, 0, 0, 8'h00, 8'hFF, 0);
    run_txn(mk(3,9,4,12,5,6,2), mk(0,0,0,0,0,0,0), 0, 2'd0, 0, 0, 8'h00, 8'h96, 0);
    run_txn(mk(3,9,4,12,5,6,2), mk(0,0,0,0,0,0,0), 1, 2'd0, 0, 0, 8'h44, 8'h00, 0);
    run_txn(mk(1,3,1,3,1,0,1), mk(1,3,1,3,1,0,1), 0, 2'd2, 0, 0, 8'h00, 8'h17, 1);
    run_txn(mk(1,3,1,3,1,0,1), mk(1,3,1,3,1,0,1), 1, 2'd0, 0, 0, 8'hE8, 8'h00, 1);

    for (int t = 0; t < 40; t++) begin
      rc = $urandom;
      run_txn(rc, rc, 1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 50),
              8'($urandom), 8'($urandom), 1'($urandom % 4 == 0));
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule